// File: doc/BRIEF.md
# Bus Fault Status Word Capture

This block records what a processor bus cycle was doing when it ended in a bus error. It packs that record into a 16-bit status word, which the exception sequencer pushes onto the stack. The record holds the cycle class (instruction fetch or data operand), the transfer direction, whether the operand was a long word, the size still left to move, the 3-bit function code and a rerun request flag. The record is latched on the clock edge where the bus-error strobe is high. It is held until the next fault or until reset.

On exception return, the sequencer presents the popped status word together with an unstack strobe. When the word asks for a rerun (bit 8 set), the block reloads the direction, remaining-size and function-code fields into restore registers. It then raises a restore-valid pulse for one cycle, so the bus controller can retry the faulted transfer. The cycle-class bit, the long-word bit and every unused bit of the popped word are never used.

The remaining size is derived from the original operand size and a flag that says the first word of a long-word operand has already been moved. For a split long word, the size field therefore reports word. Byte size appears only when the operand was a byte.

Top module: `bus_fault_status`

## Requirements
- R1: Status word bit 7 is 1 when the faulted cycle was an instruction prefetch and 0 when it was an operand cycle.
- R2: Status word bit 6 is 1 for a prefetch or an operand read and 0 for an operand write.
- R3: Status word bit 5 is 1 when the original operand size was long word (code 00) and 0 for byte or word.
- R4: Status word bits 4:3 hold the remaining size, coded 00 long, 01 byte, 10 word. A long-word operand whose first word is already done shows 10. A long-word operand with no word done shows 00. Byte and word operands show their own code.
- R5: Status word bits 2:0 are a copy of the faulted cycle's function code.
- R6: Status word bit 8 is a copy of the rerun request input at the fault, and bits 15:9 are always 0.
- R7: After reset the status word is 0. A capture happens only on an edge with the bus-error strobe high, and the status word then holds unchanged until the next capture.
- R8: An unstack strobe whose word has bit 8 set loads the restore outputs from word bit 6 (direction), bits 4:3 (size) and bits 2:0 (function code). Restore-valid is high in the following cycle only, and the restore outputs are 0 after reset.
- R9: An unstack strobe whose word has bit 8 clear leaves restore-valid low and the restore outputs unchanged. Word bits 7, 5 and 15:9 never affect the restore outputs.
- R10: When the bus-error strobe and an unstack strobe are high on the same edge, the new capture is taken and the restore is dropped: restore-valid stays low and the restore outputs are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_i | input | 1 | Bus-error strobe; capture on this edge |
| fetch_i | input | 1 | Faulted cycle was an instruction prefetch |
| read_i | input | 1 | Faulted operand cycle was a read |
| op_size_i | input | 2 | Original operand size (00 long, 01 byte, 10 word) |
| half_done_i | input | 1 | First word of a long-word operand already transferred |
| fc_i | input | 3 | Function code of the faulted cycle |
| rerun_i | input | 1 | Rerun request to record in bit 8 |
| status_o | output | 16 | Packed status word |
| unstack_i | input | 1 | Unstack strobe during exception return |
| popped_i | input | 16 | Status word read back from the stack |
| rst_valid_o | output | 1 | One-cycle pulse: restore values are fresh |
| rst_rw_o | output | 1 | Restored direction bit |
| rst_size_o | output | 2 | Restored remaining size |
| rst_fc_o | output | 3 | Restored function code |

## Verification
The bench builds the block with its default parameters: a 16-bit word and a 3-bit function code. With these, every field position, including the always-zero upper bits 15:9, can be observed directly at the ports. Random faults cover all fetch, direction, size and split-long combinations. Random unstack words set junk in the ignored bits. Directed cases cover the split long word, the byte case, a rerun-clear unstack and a fault colliding with an unstack.

// File: rtl/bfs_pkg.sv
package bfs_pkg;
  localparam int FC_W = 3;
  localparam int SZ_W = 2;

  // bit positions inside the packed status word
  localparam int POS_FC = 0;
  localparam int POS_SZ = POS_FC + FC_W;
  localparam int POS_LG = POS_SZ + SZ_W;
  localparam int POS_RW = POS_LG + 1;
  localparam int POS_IN = POS_RW + 1;
  localparam int POS_RR = POS_IN + 1;
  localparam int USED_W = POS_RR + 1;

  typedef enum logic [SZ_W-1:0] {
    SZ_LONG = 2'b00,
    SZ_BYTE = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } size_e;

  typedef struct packed {
    logic            rr;
    logic            in;
    logic            rw;
    logic            lg;
    logic [SZ_W-1:0] sz;
    logic [FC_W-1:0] fc;
  } fault_rec_t;
endpackage

// File: rtl/bfs_capture.sv
module bfs_capture
  import bfs_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fault_i,
  input  logic            fetch_i,
  input  logic            read_i,
  input  logic [SZ_W-1:0] op_size_i,
  input  logic            half_done_i,
  input  logic [FC_W-1:0] fc_i,
  input  logic            rerun_i,
  output fault_rec_t      rec_o
);
  fault_rec_t rec_q, rec_d, rec_new;

  always_comb begin
    rec_new.rr = rerun_i;
    rec_new.in = fetch_i;
    rec_new.rw = fetch_i | read_i;
    rec_new.lg = (op_size_i == SZ_LONG);
    if ((op_size_i == SZ_LONG) && half_done_i)
      rec_new.sz = SZ_WORD;
    else
      rec_new.sz = op_size_i;
    rec_new.fc = fc_i;
  end

  always_comb begin
    rec_d = rec_q;
    if (fault_i) rec_d = rec_new;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rec_q <= '0;
    else        rec_q <= rec_d;
  end

  assign rec_o = rec_q;
endmodule

// File: rtl/bfs_pack.sv
module bfs_pack
  import bfs_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  fault_rec_t        rec_i,
  output logic [WORD_W-1:0] word_o
);
  localparam int PAD_W = WORD_W - USED_W;

  generate
    if (PAD_W > 0) begin : g_pad
      assign word_o = {{PAD_W{1'b0}}, rec_i};
    end else begin : g_nopad
      assign word_o = rec_i;
    end
  endgenerate
endmodule

// File: rtl/bfs_restore.sv
module bfs_restore
  import bfs_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              unstack_i,
  input  logic              fault_i,
  input  logic [WORD_W-1:0] popped_i,
  output logic              valid_o,
  output logic              rw_o,
  output logic [SZ_W-1:0]   size_o,
  output logic [FC_W-1:0]   fc_o
);
  logic            load;
  logic            valid_q, valid_d;
  logic            rw_q, rw_d;
  logic [SZ_W-1:0] sz_q, sz_d;
  logic [FC_W-1:0] fc_q, fc_d;

  // a fault on the same edge wins over a restore request
  assign load = unstack_i & popped_i[POS_RR] & ~fault_i;

  always_comb begin
    valid_d = load;
    rw_d    = rw_q;
    sz_d    = sz_q;
    fc_d    = fc_q;
    if (load) begin
      rw_d = popped_i[POS_RW];
      sz_d = popped_i[POS_SZ +: SZ_W];
      fc_d = popped_i[POS_FC +: FC_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      rw_q    <= 1'b0;
      sz_q    <= '0;
      fc_q    <= '0;
    end else begin
      valid_q <= valid_d;
      rw_q    <= rw_d;
      sz_q    <= sz_d;
      fc_q    <= fc_d;
    end
  end

  assign valid_o = valid_q;
  assign rw_o    = rw_q;
  assign size_o  = sz_q;
  assign fc_o    = fc_q;
endmodule

// File: rtl/bus_fault_status.sv
module bus_fault_status
  import bfs_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fault_i,
  input  logic              fetch_i,
  input  logic              read_i,
  input  logic [SZ_W-1:0]   op_size_i,
  input  logic              half_done_i,
  input  logic [FC_W-1:0]   fc_i,
  input  logic              rerun_i,
  output logic [WORD_W-1:0] status_o,
  input  logic              unstack_i,
  input  logic [WORD_W-1:0] popped_i,
  output logic              rst_valid_o,
  output logic              rst_rw_o,
  output logic [SZ_W-1:0]   rst_size_o,
  output logic [FC_W-1:0]   rst_fc_o
);
  fault_rec_t rec;

  bfs_capture u_capture (
    .clk         (clk),
    .rst_n       (rst_n),
    .fault_i     (fault_i),
    .fetch_i     (fetch_i),
    .read_i      (read_i),
    .op_size_i   (op_size_i),
    .half_done_i (half_done_i),
    .fc_i        (fc_i),
    .rerun_i     (rerun_i),
    .rec_o       (rec)
  );

  bfs_pack #(.WORD_W(WORD_W)) u_pack (
    .rec_i  (rec),
    .word_o (status_o)
  );

  bfs_restore #(.WORD_W(WORD_W)) u_restore (
    .clk       (clk),
    .rst_n     (rst_n),
    .unstack_i (unstack_i),
    .fault_i   (fault_i),
    .popped_i  (popped_i),
    .valid_o   (rst_valid_o),
    .rw_o      (rst_rw_o),
    .size_o    (rst_size_o),
    .fc_o      (rst_fc_o)
  );
endmodule

// File: rtl/bfs_checker.sv
module bfs_checker
  import bfs_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fault_i,
  input logic [FC_W-1:0]   fc_i,
  input logic              fetch_i,
  input logic [WORD_W-1:0] status_o,
  input logic              unstack_i,
  input logic [WORD_W-1:0] popped_i,
  input logic              rst_valid_o,
  input logic [FC_W-1:0]   rst_fc_o,
  input logic [SZ_W-1:0]   rst_size_o
);
  a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[WORD_W-1:USED_W] == '0);

  a_r5_fc_copied: assert property (@(posedge clk) disable iff (!rst_n)
    fault_i |=> status_o[POS_FC +: FC_W] == $past(fc_i));

  a_r1_in_bit: assert property (@(posedge clk) disable iff (!rst_n)
    fault_i |=> status_o[POS_IN] == $past(fetch_i));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_i |=> $stable(status_o));

  a_r8_valid_cause: assert property (@(posedge clk) disable iff (!rst_n)
    unstack_i && popped_i[POS_RR] && !fault_i |=> rst_valid_o);

  a_r8_fields: assert property (@(posedge clk) disable iff (!rst_n)
    unstack_i && popped_i[POS_RR] && !fault_i |=>
      rst_fc_o == $past(popped_i[POS_FC +: FC_W]) &&
      rst_size_o == $past(popped_i[POS_SZ +: SZ_W]));

  a_r9_no_rerun: assert property (@(posedge clk) disable iff (!rst_n)
    !(unstack_i && popped_i[POS_RR]) |=> !rst_valid_o && $stable(rst_fc_o));

  a_r10_fault_wins: assert property (@(posedge clk) disable iff (!rst_n)
    fault_i |=> !rst_valid_o && $stable(rst_size_o));
endmodule

bind bus_fault_status bfs_checker #(.WORD_W(WORD_W)) u_bfs_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .fault_i     (fault_i),
  .fc_i        (fc_i),
  .fetch_i     (fetch_i),
  .status_o    (status_o),
  .unstack_i   (unstack_i),
  .popped_i    (popped_i),
  .rst_valid_o (rst_valid_o),
  .rst_fc_o    (rst_fc_o),
  .rst_size_o  (rst_size_o)
);

// File: tb/test_bus_fault_status.sv
`timescale 1ns/1ps
module test_bus_fault_status;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        fault_i, fetch_i, read_i, half_done_i, rerun_i, unstack_i;
  logic [1:0]  op_size_i;
  logic [2:0]  fc_i;
  logic [15:0] popped_i;
  logic [15:0] status_o;
  logic        rst_valid_o, rst_rw_o;
  logic [1:0]  rst_size_o;
  logic [2:0]  rst_fc_o;

  int n_chk = 0;
  int n_bad = 0;

  // expected state
  logic [15:0] e_stat;
  logic        e_val, e_rw;
  logic [1:0]  e_sz;
  logic [2:0]  e_fc;

  always #2 clk = ~clk;

  bus_fault_status i_bus_fault_status (.*);

  function automatic logic [15:0] pack_exp(input logic rr, input logic fe, input logic rd,
                                           input logic [1:0] sz, input logic hd,
                                           input logic [2:0] fc);
    logic [1:0] rem;
    rem = (sz == 2'b00 && hd) ? 2'b10 : sz;
    return {7'b0, rr, fe, fe | rd, sz == 2'b00, rem, fc};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    fault_i = 0; fetch_i = 0; read_i = 0; half_done_i = 0; rerun_i = 0;
    unstack_i = 0; op_size_i = 0; fc_i = 0; popped_i = 0;
  endtask

  // apply inputs at negedge, update model at posedge, compare at next negedge
  task automatic step();
    @(posedge clk);
    e_val = 1'b0;
    if (fault_i)
      e_stat = pack_exp(rerun_i, fetch_i, read_i, op_size_i, half_done_i, fc_i);
    else if (unstack_i && popped_i[8]) begin
      e_val = 1'b1;
      e_rw  = popped_i[6];
      e_sz  = popped_i[4:3];
      e_fc  = popped_i[2:0];
    end
    @(negedge clk);
    chk("R1-in", {31'b0, status_o[7]}, {31'b0, e_stat[7]});
    chk("R2-rw", {31'b0, status_o[6]}, {31'b0, e_stat[6]});
    chk("R3-lg", {31'b0, status_o[5]}, {31'b0, e_stat[5]});
    chk("R4-siz", {30'b0, status_o[4:3]}, {30'b0, e_stat[4:3]});
    chk("R5-fc", {29'b0, status_o[2:0]}, {29'b0, e_stat[2:0]});
    chk("R6-rr", {16'b0, status_o[15:8]}, {16'b0, e_stat[15:8]});
    chk("R8-valid", {31'b0, rst_valid_o}, {31'b0, e_val});
    chk("R9-restore", {26'b0, rst_rw_o, rst_size_o, rst_fc_o}, {26'b0, e_rw, e_sz, e_fc});
    idle_inputs();
  endtask

  task automatic fault(input logic rr, input logic fe, input logic rd,
                       input logic [1:0] sz, input logic hd, input logic [2:0] fc);
    fault_i = 1; rerun_i = rr; fetch_i = fe; read_i = rd;
    op_size_i = sz; half_done_i = hd; fc_i = fc;
  endtask

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    idle_inputs();
    rst_n = 0;
    e_stat = 0; e_val = 0; e_rw = 0; e_sz = 0; e_fc = 0;
    repeat (3) @(negedge clk);
    // R7: reset state
    chk("R7-reset-word", {16'b0, status_o}, 32'd0);
    chk("R8-reset-restore", {25'b0, rst_valid_o, rst_rw_o, rst_size_o, rst_fc_o}, 32'd0);
    rst_n = 1;
    step();

    // R4: split long word shows word size; LG set
    fault(1, 0, 1, 2'b00, 1, 3'd5); step();
    // R4: long with nothing done shows long
    fault(0, 0, 0, 2'b00, 0, 3'd1); step();
    // R4: byte shows byte even with half_done high
    fault(0, 1, 0, 2'b01, 1, 3'd6); step();
    // R7: hold for several idle cycles
    repeat (3) step();
    // R8: rerun set, junk in ignored bits
    popped_i = 16'hFE00 | 16'h0100 | 16'h00A0 | 16'h0040 | 16'h0010 | 16'h0003;
    unstack_i = 1; step(); step();
    // R9: rerun clear, restore untouched
    popped_i = 16'hFEFF & ~16'h0100; unstack_i = 1; step();
    // R10: collision, capture wins
    fault(0, 0, 1, 2'b10, 0, 3'd2);
    unstack_i = 1; popped_i = 16'h0157; step();

    for (int i = 0; i < 400; i++) begin
      int kind;
      kind = $urandom_range(0, 3);
      if (kind == 1 || kind == 3) begin
        logic [1:0] sz;
        sz = 2'($urandom_range(0, 2));
        fault(1'($urandom), 1'($urandom), 1'($urandom), sz, 1'($urandom), 3'($urandom));
      end
      if (kind >= 2) begin
        unstack_i = 1;
        popped_i = 16'($urandom);
      end
      step();
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule